// File: doc/BRIEF.md
# Interleaved ADC Lane Combiner

Four ADC cores each deliver a vector of raw 12-bit samples every processing cycle. This block regroups those vectors into up to four output streams according to a channel mode held in a configuration register. In the interleaved modes, two or four cores that sample one input at staggered phases are merged into a single time-ordered vector of 16 or 32 samples. In the duplicate-sampling modes, two or four cores (or two pairs of cores) sample the same input independently. Each copy either leaves on its own stream, or the copies are averaged sample by sample into one stream.

Every raw code is treated as offset binary and converted to a left-aligned signed 16-bit value before it is routed. Results appear one clock after the input vector. A new mode or averaging setting is taken only on clock edges where no input vector is presented, so a burst of vectors is never split between two layouts.

Top module: `ilc_lane_combiner`

## Requirements
- R1: Every output sample is the raw code minus 2048, multiplied by 16, as a 16-bit two's complement value (raw 0 gives 0x8000, raw 2048 gives 0x0000, raw 4095 gives 0x7FF0, raw 1 gives 0x8010).
- R2: Mode code 0 (four-way interleave): stream 0 carries 32 samples, where sample k is core (k mod 4), local sample (k div 4). Only stream 0 is valid. The averaging enable has no effect.
- R3: Mode code 1 (two pairs interleaved): stream 0 sample k (k < 16) is core (k mod 2), local sample (k div 2). Stream 1 sample k is core 2 + (k mod 2), local sample (k div 2). Streams 0 and 1 are valid, and samples 16 to 31 of both are zero. The averaging enable has no effect.
- R4: Mode code 2 (independent cores): stream c, samples 0 to 7, is core c. All four streams are valid. The averaging enable has no effect.
- R5: Mode code 3 (one input taken twice, each copy a two-core interleave): with averaging off, the output matches R3. With averaging on, stream 0 sample k (k < 16) is floor((A_k + B_k) / 2), where A is the interleave of cores 0 and 1 and B is the interleave of cores 2 and 3. In that case only stream 0 is valid.
- R6: Mode code 4 (one input taken four times): with averaging off, the output matches R4. With averaging on, stream 0 sample j (j < 8) is floor of the sum of the four cores' sample j divided by 4, and only stream 0 is valid.
- R7: Mode code 5 (two inputs, each taken twice): with averaging off, the output matches R4. With averaging on, stream 0 sample j is floor((core0_j + core1_j) / 2) and stream 1 sample j is floor((core2_j + core3_j) / 2). Only streams 0 and 1 are valid.
- R8: Mode codes 6 and 7 are reserved. No stream is valid and all output data is zero.
- R9: Output valid and data appear exactly one clock after the input vector is captured. On an edge where the input valid is low, every valid flag and every data bit is zero after that edge. Unused streams, and unused samples within a stream, are zero.
- R10: The mode and averaging inputs are captured only on edges where the input valid is low. While the input valid is high, changes on them have no effect.
- R11: A synchronous active-low reset clears all outputs and sets the configuration to mode code 0 with averaging off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A core vector set is present this cycle |
| core_data | input | 384 | Raw codes; core c sample j at bits [(c*8+j)*12 +: 12] |
| mode_sel | input | 3 | Channel mode code, captured while in_valid is low |
| avg_en | input | 1 | Averaging enable for duplicate-sampling modes, captured while in_valid is low |
| out_valid | output | 4 | Per-stream valid flags, bit s for stream s |
| out_data | output | 2048 | Stream s sample k at bits [(s*32+k)*16 +: 16] |

## Verification
A wrong configuration register shows at the ports one cycle after the next input vector. The valid mask and the sample layout then match a different mode, so comparing the valid mask and every stream against a bench model catches it on that vector. A wrong interleave index or a wrong averaging shift corrupts specific sample positions in that same output cycle. Checks on extreme codes (0 and 4095 mixed) expose sign-handling errors in the sum. Residue left in the output register shows up as nonzero data on the first cycle after an idle edge.

// File: rtl/ilc_pkg.sv
`timescale 1ns/1ps
// Package: ilc_pkg
// Shared constants and mode encoding for the interleaved ADC lane combiner.
// Assumes exactly four cores and four output streams; mode codes 6 and 7 are reserved.
package ilc_pkg;
    localparam int NCORE = 4;
    localparam int NSTR  = 4;

    typedef enum logic [2:0] {
        MODE_INTLV4  = 3'd0,
        MODE_INTLV2  = 3'd1,
        MODE_INDEP   = 3'd2,
        MODE_DUP2    = 3'd3,
        MODE_DUP4    = 3'd4,
        MODE_DUP2X2  = 3'd5
    } chmode_e;
endpackage

// File: rtl/ilc_sample_map.sv
`timescale 1ns/1ps
// Module: ilc_sample_map
// Converts every raw offset-binary code into a left-aligned two's complement value:
// (raw - 2^(RAW_W-1)) << (OUT_W - RAW_W). Purely combinational.
// Assumes OUT_W >= RAW_W >= 2.
module ilc_sample_map #(
    parameter int NCORE = 4,
    parameter int SPC   = 8,
    parameter int RAW_W = 12,
    parameter int OUT_W = 16
) (
    input  logic [NCORE-1:0][SPC-1:0][RAW_W-1:0] raw,
    output logic [NCORE-1:0][SPC-1:0][OUT_W-1:0] conv
);
    localparam int PAD = OUT_W - RAW_W;

    // Per-sample conversion: invert the MSB (offset removal) and append zero padding.
    for (genvar c = 0; c < NCORE; c++) begin : g_core
        for (genvar j = 0; j < SPC; j++) begin : g_smp
            if (PAD > 0) begin : g_pad
                assign conv[c][j] = {~raw[c][j][RAW_W-1], raw[c][j][RAW_W-2:0], {PAD{1'b0}}};
            end else begin : g_nopad
                assign conv[c][j] = {~raw[c][j][RAW_W-1], raw[c][j][RAW_W-2:0]};
            end
        end
    end
endmodule

// File: rtl/ilc_interleave.sv
`timescale 1ns/1ps
// Module: ilc_interleave
// Merges N core vectors into one time-linear vector: output index k takes
// core (k mod N), local sample (k div N). Core 0 holds the earliest phase.
// Purely combinational wiring.
module ilc_interleave #(
    parameter int N   = 2,
    parameter int SPC = 8,
    parameter int W   = 16
) (
    input  logic [N-1:0][SPC-1:0][W-1:0] lanes,
    output logic [N*SPC-1:0][W-1:0]      merged
);
    // Phase-ordered pick of each output position.
    for (genvar k = 0; k < N*SPC; k++) begin : g_pos
        assign merged[k] = lanes[k % N][k / N];
    end
endmodule

// File: rtl/ilc_average.sv
`timescale 1ns/1ps
// Module: ilc_average
// Sample-wise mean of N signed vectors: widened sum, then arithmetic right
// shift by log2(N), which rounds toward negative infinity.
// Assumes N is a power of two. Purely combinational.
module ilc_average #(
    parameter int N   = 2,
    parameter int LEN = 8,
    parameter int W   = 16
) (
    input  logic [N-1:0][LEN-1:0][W-1:0] ops,
    output logic [LEN-1:0][W-1:0]        mean
);
    localparam int SH = $clog2(N);
    localparam int SW = W + SH;

    // Sum each sample position across operands, then scale down.
    always_comb begin
        logic signed [SW-1:0] acc;
        for (int i = 0; i < LEN; i++) begin
            acc = '0;
            for (int n = 0; n < N; n++) begin
                acc = acc + SW'($signed(ops[n][i]));
            end
            mean[i] = W'(acc >>> SH);
        end
    end
endmodule

// File: rtl/ilc_lane_combiner.sv
`timescale 1ns/1ps
// Module: ilc_lane_combiner (top)
// Regroups four ADC core vectors into up to four output streams according to
// a registered channel mode: interleaved merges, independent lanes, or sample
// averages of duplicate samplings. One register stage from input to output.
// Assumes: configuration is captured only while in_valid is low; unused
// streams and samples are driven to zero; reset is synchronous, active low.
module ilc_lane_combiner
    import ilc_pkg::*;
#(
    parameter int SPC   = 8,
    parameter int RAW_W = 12,
    parameter int OUT_W = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic [NCORE*SPC*RAW_W-1:0]    core_data,
    input  logic [2:0]                    mode_sel,
    input  logic                          avg_en,
    output logic [NSTR-1:0]               out_valid,
    output logic [NSTR*NCORE*SPC*OUT_W-1:0] out_data
);
    localparam int MAXS = NCORE * SPC;
    localparam int PAIR = 2 * SPC;

    logic [NCORE-1:0][SPC-1:0][RAW_W-1:0] raw_v;
    logic [NCORE-1:0][SPC-1:0][OUT_W-1:0] cv;
    logic [MAXS-1:0][OUT_W-1:0]           il_all;
    logic [PAIR-1:0][OUT_W-1:0]           il_lo, il_hi, avg_pair;
    logic [SPC-1:0][OUT_W-1:0]            avg_quad, avg_lo, avg_hi;

    chmode_e mode_q;
    logic    avg_q;

    logic [NSTR-1:0][MAXS-1:0][OUT_W-1:0] nxt_data, data_q;
    logic [NSTR-1:0]                      nxt_val, val_q;

    assign raw_v = core_data;

    ilc_sample_map #(.NCORE(NCORE), .SPC(SPC), .RAW_W(RAW_W), .OUT_W(OUT_W))
        u_map (.raw(raw_v), .conv(cv));

    ilc_interleave #(.N(4), .SPC(SPC), .W(OUT_W)) u_il_all (.lanes(cv),      .merged(il_all));
    ilc_interleave #(.N(2), .SPC(SPC), .W(OUT_W)) u_il_lo  (.lanes(cv[1:0]), .merged(il_lo));
    ilc_interleave #(.N(2), .SPC(SPC), .W(OUT_W)) u_il_hi  (.lanes(cv[3:2]), .merged(il_hi));

    ilc_average #(.N(2), .LEN(PAIR), .W(OUT_W)) u_avg_pair (.ops({il_hi, il_lo}), .mean(avg_pair));
    ilc_average #(.N(4), .LEN(SPC),  .W(OUT_W)) u_avg_quad (.ops(cv),             .mean(avg_quad));
    ilc_average #(.N(2), .LEN(SPC),  .W(OUT_W)) u_avg_lo   (.ops(cv[1:0]),        .mean(avg_lo));
    ilc_average #(.N(2), .LEN(SPC),  .W(OUT_W)) u_avg_hi   (.ops(cv[3:2]),        .mean(avg_hi));

    // Configuration capture: only on idle edges so a burst keeps one layout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_INTLV4;
            avg_q  <= 1'b0;
        end else if (!in_valid) begin
            mode_q <= chmode_e'(mode_sel);
            avg_q  <= avg_en;
        end
    end

    // Stream routing: pick the layout for the active mode; the rest stays zero.
    always_comb begin
        nxt_data = '0;
        nxt_val  = '0;
        case (mode_q)
            MODE_INTLV4: begin
                nxt_data[0] = il_all;
                nxt_val     = 4'b0001;
            end
            MODE_INTLV2: begin
                nxt_data[0][PAIR-1:0] = il_lo;
                nxt_data[1][PAIR-1:0] = il_hi;
                nxt_val               = 4'b0011;
            end
            MODE_DUP2: begin
                if (avg_q) begin
                    nxt_data[0][PAIR-1:0] = avg_pair;
                    nxt_val               = 4'b0001;
                end else begin
                    nxt_data[0][PAIR-1:0] = il_lo;
                    nxt_data[1][PAIR-1:0] = il_hi;
                    nxt_val               = 4'b0011;
                end
            end
            MODE_DUP4: begin
                if (avg_q) begin
                    nxt_data[0][SPC-1:0] = avg_quad;
                    nxt_val              = 4'b0001;
                end else begin
                    for (int c = 0; c < NCORE; c++) nxt_data[c][SPC-1:0] = cv[c];
                    nxt_val = 4'b1111;
                end
            end
            MODE_DUP2X2: begin
                if (avg_q) begin
                    nxt_data[0][SPC-1:0] = avg_lo;
                    nxt_data[1][SPC-1:0] = avg_hi;
                    nxt_val              = 4'b0011;
                end else begin
                    for (int c = 0; c < NCORE; c++) nxt_data[c][SPC-1:0] = cv[c];
                    nxt_val = 4'b1111;
                end
            end
            MODE_INDEP: begin
                for (int c = 0; c < NCORE; c++) nxt_data[c][SPC-1:0] = cv[c];
                nxt_val = 4'b1111;
            end
            default: begin
                nxt_data = '0;
                nxt_val  = '0;
            end
        endcase
    end

    // Output stage: one-cycle latency; idle edges clear flags and data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            val_q  <= '0;
        end else if (in_valid) begin
            data_q <= nxt_data;
            val_q  <= nxt_val;
        end else begin
            data_q <= '0;
            val_q  <= '0;
        end
    end

    assign out_data  = data_q;
    assign out_valid = val_q;

    // An idle input edge leaves nothing valid and no stale data behind.
    assert_idle_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (out_valid == '0 && out_data == '0));

    // Any valid output stream traces back to a captured input vector.
    assert_valid_origin_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid != '0) |-> $past(in_valid));

    // Configuration cannot move while a vector is being presented.
    assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ($stable(mode_q) && $stable(avg_q)));

    // Four-way interleave drives stream 0 only.
    assert_single_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode_q == MODE_INTLV4) |=> out_valid == 4'b0001);

    // Reserved codes never produce a valid stream.
    assert_reserved_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (mode_q == chmode_e'(3'd6) || mode_q == chmode_e'(3'd7))) |=> out_valid == '0);
endmodule

// File: tb/test_ilc_lane_combiner.sv
`timescale 1ns/1ps
module test_ilc_lane_combiner;
    localparam int NC    = 4;
    localparam int SPC   = 8;
    localparam int MAXS  = 32;
    localparam int RAW_W = 12;
    localparam int OUT_W = 16;
    localparam int SW    = MAXS * OUT_W;

    typedef struct packed {
        logic [2:0]  mode;
        logic        avg;
        logic [11:0] seed;   // 0 selects the extreme pattern
        logic [3:0]  vmask;  // expected valid flags
    } vec_t;

    localparam int NVEC = 17;
    localparam vec_t VECS [NVEC] = '{
        '{3'd0, 1'b0, 12'd5,    4'b0001},
        '{3'd0, 1'b1, 12'd0,    4'b0001},
        '{3'd1, 1'b0, 12'd77,   4'b0011},
        '{3'd1, 1'b1, 12'd60,   4'b0011},
        '{3'd2, 1'b0, 12'd300,  4'b1111},
        '{3'd2, 1'b1, 12'd88,   4'b1111},
        '{3'd3, 1'b0, 12'd41,   4'b0011},
        '{3'd3, 1'b1, 12'd0,    4'b0001},
        '{3'd3, 1'b1, 12'd913,  4'b0001},
        '{3'd4, 1'b0, 12'd222,  4'b1111},
        '{3'd4, 1'b1, 12'd0,    4'b0001},
        '{3'd4, 1'b1, 12'd1500, 4'b0001},
        '{3'd5, 1'b0, 12'd9,    4'b1111},
        '{3'd5, 1'b1, 12'd0,    4'b0011},
        '{3'd5, 1'b1, 12'd2718, 4'b0011},
        '{3'd6, 1'b0, 12'd123,  4'b0000},
        '{3'd7, 1'b1, 12'd55,   4'b0000}
    };

    logic                       clk = 1'b0;
    logic                       rst_n;
    logic                       in_valid;
    logic [NC*SPC*RAW_W-1:0]    core_data;
    logic [2:0]                 mode_sel;
    logic                       avg_en;
    logic [3:0]                 out_valid;
    logic [4*SW-1:0]            out_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic [11:0]      raw [NC][SPC];
    logic [OUT_W-1:0] ex  [NC][MAXS];

    always #2.5 clk = ~clk;

    ilc_lane_combiner i_ilc_lane_combiner (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .core_data(core_data),
        .mode_sel(mode_sel), .avg_en(avg_en), .out_valid(out_valid), .out_data(out_data)
    );

    function automatic int sval(logic [11:0] r);
        return (int'(r) - 2048) * 16;
    endfunction

    function automatic string req_of(logic [2:0] m);
        case (m)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R5";
            3'd4: return "R6";
            3'd5: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic fill_raw(logic [11:0] seed);
        for (int c = 0; c < NC; c++)
            for (int j = 0; j < SPC; j++)
                if (seed == 0) raw[c][j] = c[0] ? 12'd4095 : 12'd0;
                else raw[c][j] = 12'(int'(seed) * (j + 1) + c * 1031 + j * 277);
    endtask

    task automatic pack_raw();
        for (int c = 0; c < NC; c++)
            for (int j = 0; j < SPC; j++)
                core_data[(c*SPC+j)*RAW_W +: RAW_W] = raw[c][j];
    endtask

    task automatic expect_indep();
        for (int c = 0; c < NC; c++)
            for (int j = 0; j < SPC; j++) ex[c][j] = 16'(sval(raw[c][j]));
    endtask

    task automatic expect_pairs();
        for (int k = 0; k < 16; k++) begin
            ex[0][k] = 16'(sval(raw[k%2][k/2]));
            ex[1][k] = 16'(sval(raw[2 + k%2][k/2]));
        end
    endtask

    task automatic build_expect(logic [2:0] m, logic a);
        int s;
        for (int c = 0; c < NC; c++)
            for (int k = 0; k < MAXS; k++) ex[c][k] = '0;
        case (m)
            3'd0: for (int k = 0; k < 32; k++) ex[0][k] = 16'(sval(raw[k%4][k/4]));
            3'd1: expect_pairs();
            3'd2: expect_indep();
            3'd3: if (a) begin
                      for (int k = 0; k < 16; k++) begin
                          s = sval(raw[k%2][k/2]) + sval(raw[2 + k%2][k/2]);
                          ex[0][k] = 16'(s >>> 1);
                      end
                  end else expect_pairs();
            3'd4: if (a) begin
                      for (int j = 0; j < SPC; j++) begin
                          s = sval(raw[0][j]) + sval(raw[1][j]) + sval(raw[2][j]) + sval(raw[3][j]);
                          ex[0][j] = 16'(s >>> 2);
                      end
                  end else expect_indep();
            3'd5: if (a) begin
                      for (int j = 0; j < SPC; j++) begin
                          ex[0][j] = 16'((sval(raw[0][j]) + sval(raw[1][j])) >>> 1);
                          ex[1][j] = 16'((sval(raw[2][j]) + sval(raw[3][j])) >>> 1);
                      end
                  end else expect_indep();
            default: ;
        endcase
    endtask

    task automatic check_streams(logic [3:0] vmask, string tag);
        logic [SW-1:0] want;
        for (int s = 0; s < 4; s++) begin
            for (int k = 0; k < MAXS; k++) want[k*OUT_W +: OUT_W] = ex[s][k];
            n_checks++;
            if (out_valid[s] !== vmask[s] || out_data[s*SW +: SW] !== want) begin
                n_fail++;
                $display("FAIL %s stream %0d: valid=%b data=%h expected valid=%b data=%h",
                         tag, s, out_valid[s], out_data[s*SW +: SW], vmask[s], want);
            end
        end
    endtask

    task automatic check_idle(string tag);
        n_checks++;
        if (out_valid !== 4'b0 || out_data !== '0) begin
            n_fail++;
            $display("FAIL %s: valid=%b data nonzero=%b expected valid=0000 data all zero",
                     tag, out_valid, |out_data);
        end
    endtask

    // Load a configuration on an idle edge, present one vector, check one cycle later.
    task automatic run_vec(logic [2:0] m, logic a, logic [11:0] seed, logic [3:0] vmask);
        @(negedge clk);
        in_valid = 1'b0; mode_sel = m; avg_en = a;
        @(negedge clk);
        fill_raw(seed); pack_raw(); in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        build_expect(m, a);
        check_streams(vmask, req_of(m));
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; mode_sel = 3'd2; avg_en = 1'b0; core_data = '0;
        repeat (3) @(negedge clk);
        check_idle("R11 reset state");
        rst_n = 1'b1;

        // Table walk: every mode and averaging setting (R2..R8).
        for (int v = 0; v < NVEC; v++) begin
            run_vec(VECS[v].mode, VECS[v].avg, VECS[v].seed, VECS[v].vmask);
        end

        // R9: idle edge after a vector clears everything.
        @(negedge clk);
        check_idle("R9 idle after vector");

        // R1: literal conversion points in independent mode.
        fill_raw(12'd17);
        raw[0][0] = 12'd0; raw[0][1] = 12'd2048; raw[0][2] = 12'd4095; raw[0][3] = 12'd1;
        @(negedge clk); in_valid = 1'b0; mode_sel = 3'd2; avg_en = 1'b0;
        @(negedge clk); pack_raw(); in_valid = 1'b1;
        @(negedge clk); in_valid = 1'b0;
        n_checks++;
        if (out_data[63:0] !== 64'h8010_7FF0_0000_8000) begin
            n_fail++;
            $display("FAIL R1 conversion: got %h expected %h", out_data[63:0], 64'h8010_7FF0_0000_8000);
        end

        // R10: mode/avg changes during a burst are ignored.
        @(negedge clk); in_valid = 1'b0; mode_sel = 3'd5; avg_en = 1'b0;
        @(negedge clk); fill_raw(12'd444); pack_raw(); in_valid = 1'b1; mode_sel = 3'd0; avg_en = 1'b1;
        @(negedge clk);
        build_expect(3'd5, 1'b0);
        check_streams(4'b1111, "R10 first burst vector");
        fill_raw(12'd901); pack_raw();
        @(negedge clk); in_valid = 1'b0;
        build_expect(3'd5, 1'b0);
        check_streams(4'b1111, "R10 second burst vector");
        // The idle edge just taken captured mode 0 with averaging on.
        @(negedge clk); fill_raw(12'd33); pack_raw(); in_valid = 1'b1;
        @(negedge clk); in_valid = 1'b0;
        build_expect(3'd0, 1'b1);
        check_streams(4'b0001, "R10 new mode after idle");

        // R11: mid-run reset clears outputs and restores mode 0, averaging off.
        @(negedge clk); in_valid = 1'b0; mode_sel = 3'd4; avg_en = 1'b1;
        @(negedge clk); rst_n = 1'b0; in_valid = 1'b1; mode_sel = 3'd2; fill_raw(12'd71); pack_raw();
        @(negedge clk);
        check_idle("R11 reset clears outputs");
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk); in_valid = 1'b0;
        build_expect(3'd0, 1'b0);
        check_streams(4'b0001, "R11 reset configuration");

        @(negedge clk);
        finish_run();
    end
endmodule